// File: doc/BRIEF.md
# Dual-Mode Processor Timer

This block is the timer that sits beside one processor. An external mode bit selects between two uses. In counter mode the block counts timebase ticks up to a programmable limit. When it gets there it returns to zero, sets a reached flag and raises an interrupt. In user mode the same four register words give access to a wide free-counting timer. Software loads that timer in two 32-bit halves and starts or stops it through a status word. It never interrupts.

The count advances on a single-cycle `tick` enable, expected once per 500 ns. Software uses a 32-bit port whose four word slots cover a 0x10-byte window; `addr` is the word index (byte offset divided by four). Read data is combinational from the current state and from `addr`. Read side effects and all writes take effect at the clock edge. The mode bit comes from a mode register elsewhere. A change of that bit is seen one edge later, and that edge carries out the transition actions.

Top module: `dual_mode_cpu_timer`

## Requirements
- R1: After reset the block is in counter mode, with limit 0, count 0, reached 0, irq low and running 1 (status word reads 1).
- R2: In counter mode each tick advances the count by 0x200. When the advanced value equals a nonzero limit, the count becomes 0 and reached and irq are set. With limit 0 the count runs freely from 0x7FFFFE00 back to 0, and reached is not set.
- R3: In counter mode, word 0 reads the limit and the read clears reached and irq. Word 1 reads the count in bits 30:9 with reached in bit 31. Word 2 reads 0 and word 3 reads running in bit 0.
- R4: In counter mode, a write to word 0 loads the limit (wdata AND 0x7FFFFE00), clears the count and lowers irq, and no tick is taken that cycle. A write to word 2 loads the limit and keeps the count. Writes to word 1 and word 3 change nothing.
- R5: In user mode the count is 54 bits, with bits 8:0 always zero. Each tick while running adds 0x200. Word 0 reads reached in bit 31 and count bits 53:32 in bits 21:0. Word 1 reads count bits 31:0. These reads have no side effects.
- R6: In user mode the count wraps from all ones to 0 and sets reached. irq stays low the whole time in user mode.
- R7: In user mode, a write to word 0 loads count bits 53:32 from wdata[21:0], and a write to word 1 loads bits 31:9 from wdata[31:9]. Either write clears reached, and no tick is taken that cycle. Writes to word 2 are ignored.
- R8: In user mode, writing word 3 sets running to wdata bit 0. A stopped timer holds its count.
- R9: On a change to user mode, irq is lowered and running, count and reached are cleared. Bus accesses on that edge have no effect.
- R10: On a change back to counter mode, running is set and count and limit are cleared. Bus accesses on that edge have no effect.
- R11: In counter mode a limit match on the same edge as a word 0 read leaves reached and irq set. A word 2 write on a tick edge applies the old limit to that tick.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| tick | input | 1 | Timebase step enable |
| user_mode | input | 1 | 1 selects user mode, 0 counter mode |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (for side effects) |
| addr | input | 2 | Word index in the 0x10-byte window |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for the word at addr |
| irq | output | 1 | Interrupt, counter mode only |

## Verification
Directed sequences cover a short periodic limit, where the interrupt must appear on the third tick and be cleared by a limit read. They also cover a user count loaded one step below its wrap point, which tells the user-mode reached flag apart from the interrupt. The random phase mixes ticks with small limits, so matches come often, and with near-full high and low loads in user mode, so wraps come often. It also mixes occasional mode flips, start and stop, and accesses on tick edges. Every read and the interrupt are compared against a bench model, which shows whether the slot meanings follow the mode and whether the ordering rules of R11 hold.

// File: rtl/dual_mode_cpu_timer.sv
module dual_mode_cpu_timer #(
  parameter int USER_W  = 54,
  parameter int STEP_SH = 9,
  parameter int WORD_W  = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic              user_mode,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [1:0]        addr,
  input  logic [WORD_W-1:0] wdata,
  output logic [WORD_W-1:0] rdata,
  output logic              irq
);
  localparam int CW  = USER_W - STEP_SH;
  localparam int LW  = WORD_W - 1 - STEP_SH;
  localparam int LCW = WORD_W - STEP_SH;
  localparam int HW  = USER_W - WORD_W;

  logic          mode_q, running, reached;
  logic [LW-1:0] lim;
  logic [CW-1:0] cnt;

  wire           chg     = user_mode != mode_q;
  wire [LW-1:0]  ctr_inc = cnt[LW-1:0] + 1'b1;
  wire           ctr_hit = (lim != '0) && (ctr_inc == lim);
  wire           wr0     = wr_en && addr == 2'd0;
  wire           wr1     = wr_en && addr == 2'd1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= 1'b0;
      running <= 1'b1;
      reached <= 1'b0;
      irq     <= 1'b0;
      lim     <= '0;
      cnt     <= '0;
    end else begin
      mode_q <= user_mode;
      if (chg) begin
        cnt <= '0;
        if (user_mode) begin
          irq     <= 1'b0;
          running <= 1'b0;
          reached <= 1'b0;
        end else begin
          running <= 1'b1;
          lim     <= '0;
        end
      end else if (!mode_q) begin
        if (tick && !wr0) begin
          cnt <= ctr_hit ? '0 : CW'(ctr_inc);
          if (ctr_hit) begin
            reached <= 1'b1;
            irq     <= 1'b1;
          end
        end
        if (rd_en && addr == 2'd0 && !(tick && ctr_hit)) begin
          reached <= 1'b0;
          irq     <= 1'b0;
        end
        if (wr0) begin
          lim <= wdata[WORD_W-2:STEP_SH];
          cnt <= '0;
          irq <= 1'b0;
        end
        if (wr_en && addr == 2'd2) lim <= wdata[WORD_W-2:STEP_SH];
      end else begin
        if (tick && running && !wr0 && !wr1) begin
          cnt <= cnt + 1'b1;
          if (&cnt) reached <= 1'b1;
        end
        if (wr0) begin
          cnt[CW-1:LCW] <= wdata[HW-1:0];
          reached       <= 1'b0;
        end
        if (wr1) begin
          cnt[LCW-1:0] <= wdata[WORD_W-1:STEP_SH];
          reached      <= 1'b0;
        end
        if (wr_en && addr == 2'd3) running <= wdata[0];
      end
    end
  end

  always_comb begin
    case (addr)
      2'd0: rdata = mode_q ? {reached, {(WORD_W-1-HW){1'b0}}, cnt[CW-1:LCW]}
                           : {1'b0, lim, {STEP_SH{1'b0}}};
      2'd1: rdata = mode_q ? {cnt[LCW-1:0], {STEP_SH{1'b0}}}
                           : {reached, cnt[LW-1:0], {STEP_SH{1'b0}}};
      2'd3: rdata = {{(WORD_W-1){1'b0}}, running};
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/dual_mode_cpu_timer_chk.sv
module dual_mode_cpu_timer_chk #(
  parameter int CW = 45
) (
  input logic          clk,
  input logic          rst_n,
  input logic          tick,
  input logic          user_mode,
  input logic          wr_en,
  input logic          irq,
  input logic          running,
  input logic          reached,
  input logic          mode_q,
  input logic [CW-1:0] cnt
);
  AST_USER_NO_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
    (user_mode && $past(user_mode)) |-> !irq);                       // R6
  AST_ENTER_USER_STOPPED: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(user_mode) |=> (!running && !irq && !reached));            // R9
  AST_LEAVE_USER_RUNS: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(user_mode) |=> (running && cnt == '0));                    // R10
  AST_IRQ_WITH_REACHED: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> reached);                                                // R2
  AST_IRQ_RISES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> $past(tick));                                     // R2
  AST_STOPPED_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q && user_mode && !running && !wr_en) |=> $stable(cnt));   // R8
endmodule

bind dual_mode_cpu_timer dual_mode_cpu_timer_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .tick(tick), .user_mode(user_mode),
  .wr_en(wr_en), .irq(irq), .running(running), .reached(reached),
  .mode_q(mode_q), .cnt(cnt)
);

// File: tb/dual_mode_cpu_timer_bench.sv
module dual_mode_cpu_timer_bench;
  logic        clk = 1'b0, rst_n = 1'b0;
  logic        tick = 1'b0, user_mode = 1'b0, wr_en = 1'b0, rd_en = 1'b0;
  logic [1:0]  addr = 2'd0;
  logic [31:0] wdata = 32'd0, rdata;
  logic        irq;
  int          n_cmp = 0, n_bad = 0;

  always #2 clk = ~clk;

  dual_mode_cpu_timer u_dual_mode_cpu_timer (
    .clk(clk), .rst_n(rst_n), .tick(tick), .user_mode(user_mode),
    .wr_en(wr_en), .rd_en(rd_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .irq(irq)
  );

  // reference model built from the requirements
  logic        m_mode, m_run, m_rch, m_irq;
  logic [21:0] m_lim;
  logic [44:0] m_cnt;

  function automatic logic [31:0] exp_rd(input logic [1:0] a);
    case (a)
      2'd0: return m_mode ? {m_rch, 9'd0, m_cnt[44:23]} : {1'b0, m_lim, 9'd0};
      2'd1: return m_mode ? {m_cnt[22:0], 9'd0} : {m_rch, m_cnt[21:0], 9'd0};
      2'd3: return {31'd0, m_run};
      default: return 32'd0;
    endcase
  endfunction

  function automatic string req_of(input logic md, input logic [1:0] a);
    if (a == 2'd3) return md ? "R8" : "R3";
    return md ? "R5" : "R3";
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      m_mode <= 0; m_run <= 1; m_rch <= 0; m_irq <= 0; m_lim <= 0; m_cnt <= 0;
    end else begin
      m_mode <= user_mode;
      if (user_mode != m_mode) begin
        m_cnt <= 0;
        if (user_mode) begin m_irq <= 0; m_run <= 0; m_rch <= 0; end
        else begin m_run <= 1; m_lim <= 0; end
      end else if (!m_mode) begin
        logic [21:0] nxt;
        logic        hit;
        nxt = m_cnt[21:0] + 22'd1;
        hit = (m_lim != 0) && (nxt == m_lim);
        if (tick && !(wr_en && addr == 0)) begin
          m_cnt <= hit ? 45'd0 : {23'd0, nxt};
          if (hit) begin m_rch <= 1; m_irq <= 1; end
        end
        if (rd_en && addr == 0 && !(tick && hit)) begin m_rch <= 0; m_irq <= 0; end
        if (wr_en && addr == 0) begin m_lim <= wdata[30:9]; m_cnt <= 0; m_irq <= 0; end
        if (wr_en && addr == 2) m_lim <= wdata[30:9];
      end else begin
        if (tick && m_run && !(wr_en && addr[1] == 1'b0)) begin
          m_cnt <= m_cnt + 45'd1;
          if (&m_cnt) m_rch <= 1;
        end
        if (wr_en && addr == 0) begin m_cnt[44:23] <= wdata[21:0]; m_rch <= 0; end
        if (wr_en && addr == 1) begin m_cnt[22:0] <= wdata[31:9]; m_rch <= 0; end
        if (wr_en && addr == 3) m_run <= wdata[0];
      end
    end
  end

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  // one bus cycle: drive after the falling edge, compare 1 ns later
  task automatic op(input logic we, input logic re, input logic [1:0] a,
                    input logic [31:0] d, input logic t, output logic [31:0] rd);
    @(negedge clk);
    wr_en = we; rd_en = re; addr = a; wdata = d; tick = t;
    #1;
    rd = rdata;
    if (re) chk(req_of(m_mode, a), rdata, exp_rd(a));
  endtask

  task automatic idle(input int n);
    logic [31:0] rd;
    for (int i = 0; i < n; i++) op(0, 0, 0, 0, 0, rd);
  endtask

  initial begin
    #400000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    op(0, 1, 0, 0, 0, rd); chk("R1", rd, 32'h0);
    op(0, 1, 1, 0, 0, rd); chk("R1", rd, 32'h0);
    op(0, 1, 3, 0, 0, rd); chk("R1", rd, 32'h1);
    chk("R1", {31'd0, irq}, 32'd0);

    // R2/R3/R4: limit of three steps, irq on third tick, cleared by limit read
    op(1, 0, 0, 32'h0000_0600, 0, rd);
    op(0, 0, 0, 0, 1, rd); op(0, 0, 0, 0, 1, rd);
    op(0, 1, 1, 0, 0, rd); chk("R2", rd, 32'h0000_0400);
    op(0, 0, 0, 0, 1, rd);
    idle(1); chk("R2", {31'd0, irq}, 32'd1);
    op(0, 1, 1, 0, 0, rd); chk("R3", rd, 32'h8000_0000);
    op(0, 1, 0, 0, 0, rd); chk("R3", rd, 32'h0000_0600);
    idle(1); chk("R3", {31'd0, irq}, 32'd0);
    op(1, 0, 1, 32'hFFFF_FE00, 0, rd);
    op(1, 0, 3, 32'h0, 0, rd);
    op(0, 1, 1, 0, 0, rd); chk("R4", rd, 32'h0);
    op(0, 1, 3, 0, 0, rd); chk("R4", rd, 32'h1);

    // R9/R7/R8/R6: user mode, wrap sets reached but no irq
    user_mode = 1'b1;
    idle(2);
    op(0, 1, 3, 0, 0, rd); chk("R9", rd, 32'h0);
    op(1, 0, 0, 32'h003F_FFFF, 0, rd);
    op(1, 0, 1, 32'hFFFF_FE00, 0, rd);
    op(0, 1, 0, 0, 1, rd); chk("R8", rd, 32'h003F_FFFF);
    op(1, 0, 3, 32'h1, 0, rd);
    op(0, 0, 0, 0, 1, rd);
    op(0, 1, 0, 0, 0, rd); chk("R6", rd, 32'h8000_0000);
    op(0, 1, 1, 0, 0, rd); chk("R6", rd, 32'h0);
    chk("R6", {31'd0, irq}, 32'd0);
    op(1, 0, 2, 32'h1234_5600, 1, rd);
    op(0, 1, 1, 0, 0, rd); chk("R7", rd, 32'h0000_0200);

    // R10: back to counter mode
    user_mode = 1'b0;
    idle(2);
    op(0, 1, 3, 0, 0, rd); chk("R10", rd, 32'h1);
    op(0, 1, 0, 0, 0, rd); chk("R10", rd, 32'h0);

    // random phase
    for (int c = 0; c < 40000; c++) begin
      logic        we, re, t;
      logic [1:0]  a;
      logic [31:0] d;
      int          k;
      if ($urandom % 900 == 0) user_mode = ~user_mode;
      t = ($urandom % 3 == 0);
      k = $urandom % 8;
      we = (k == 0); re = (k == 1 || k == 2);
      a = 2'($urandom % 4);
      case ($urandom % 4)
        0: d = ($urandom % 8) << 9;
        1: d = 32'h003F_FFFF;
        2: d = 32'hFFFF_F000 | ($urandom & 32'h0000_0E00);
        default: d = $urandom;
      endcase
      op(we, re, a, d, t, rd);
      if (c % 8 == 0) chk(m_mode ? "R6" : "R2", {31'd0, irq}, {31'd0, m_irq});
      if (re && a == 0 && !m_mode) chk("R11", {31'd0, irq}, {31'd0, m_irq});
    end

    idle(1);
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule